// File: doc/BRIEF.md
# Load-Use Stall Cycle Accounter

This block keeps the cycle totals for a simple in-order pipeline that can issue two instructions side by side. Each cycle an upstream issue stage may present one instruction record. The record carries group-boundary flags (opens a group, closes a group), a base cycle cost, two optional source register numbers, an optional load destination and branch information. The block adds penalties for loads whose results are used too early and for taken branches, and it keeps running totals of cycles, load-stall cycles, branch-stall cycles and taken and untaken branch counts.

Load hazards are found through a scoreboard of registers that are waiting on a load. A load sets its destination bit in a collecting mask. The collecting mask is emptied when a group opens and is copied into the checked scoreboard after every instruction. The second member of a pair therefore sees the loads of the first member, and the next group sees the loads of the whole previous group. A two-instruction group costs the larger of its two members' totals. The stall totals still take every member's stall.

A two-state machine tracks group boundaries. In the state `S_SOLO` no group is open. The transition `T_OPEN` (a valid record that opens but does not close a group) moves it to `S_PAIRED`. In `S_PAIRED` the opening member's total is held. The transition `T_CLOSE` (a valid record that closes the group) returns it to `S_SOLO`. A record that both opens and closes a group is a lone instruction and leaves the state in `S_SOLO`.

Top module: `stall_accounter`

## Requirements
- R1: A synchronous active-high reset clears all five counters, both register masks and the held group maximum, and returns the state machine to `S_SOLO`.
- R2: When `iv_valid` is low, no counter and no mask changes, whatever the other inputs are.
- R3: Each source whose valid flag is set and whose register bit is set in the checked scoreboard adds 2 load-stall cycles. The two sources are charged separately, so both together add 4. A source whose valid flag is clear is never charged.
- R4: A load with `iv_ld_vld` high sets bit `iv_ld_dst` of the collecting mask, which is emptied first when `iv_first` is high. The collecting mask is copied into the checked scoreboard after every valid record. A load is therefore seen by the next record, but not by a group that opens after an intervening group without loads.
- R5: A record with `iv_br` high and `iv_br_taken` high adds 2 branch-stall cycles and increments `taken_cnt`. With `iv_br` high and `iv_br_taken` low, it adds no stall and increments `untaken_cnt`. With `iv_br` low, neither happens.
- R6: A record's total is its base cost plus its load stall plus its branch stall. A record with both `iv_first` and `iv_last` high adds that total to `tot_cycles`.
- R7: A record with `iv_first` high and `iv_last` low leaves `tot_cycles` unchanged and holds its total as the group maximum.
- R8: A record that closes an open group adds to `tot_cycles` the larger of its own total and the held maximum.
- R9: The load-stall and branch-stall totals take every record's stalls, whether or not the record closes a group.
- R10: All counters are `CNT_W` bits wide and wrap modulo 2^`CNT_W`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iv_valid | input | 1 | An instruction record is presented this cycle |
| iv_first | input | 1 | Record opens an issue group |
| iv_last | input | 1 | Record closes an issue group |
| iv_base | input | BASE_W | Base cycle cost of the record |
| iv_src0_vld | input | 1 | Source 0 is used |
| iv_src0 | input | RID_W | Source 0 register number |
| iv_src1_vld | input | 1 | Source 1 is used |
| iv_src1 | input | RID_W | Source 1 register number |
| iv_ld_vld | input | 1 | Record is a load |
| iv_ld_dst | input | RID_W | Load destination register number |
| iv_br | input | 1 | Record is a branch |
| iv_br_taken | input | 1 | The branch is taken |
| tot_cycles | output | CNT_W | Total cycle count |
| ld_stall_cycles | output | CNT_W | Accumulated load-stall cycles |
| br_stall_cycles | output | CNT_W | Accumulated branch-stall cycles |
| taken_cnt | output | CNT_W | Taken-branch count |
| untaken_cnt | output | CNT_W | Untaken-branch count |

## Verification
The bench keeps 16 registers and the 2-cycle penalty at their default values. It sets `CNT_W` to 12, so that seventeen records of the largest 8-bit base cost carry `tot_cycles` past 4095 and the wrap in R10 is reached in a few cycles. With the 16-entry scoreboard, register 15 and register 0 are both used, so both ends of the destination and source decoders are covered.

// File: rtl/stall_acct_pkg.sv
package stall_acct_pkg;
    typedef enum logic {
        S_SOLO   = 1'b0,
        S_PAIRED = 1'b1
    } grp_state_e;

    localparam int NSRC = 2;
endpackage

// File: rtl/ld_hazard_probe.sv
module ld_hazard_probe #(
    parameter int NREG  = 16,
    parameter int CNT_W = 32,
    parameter int PEN   = 2,
    localparam int RID_W = $clog2(NREG)
) (
    input  logic [NREG-1:0]                       active_mask,
    input  logic [stall_acct_pkg::NSRC-1:0]        src_vld,
    input  logic [stall_acct_pkg::NSRC-1:0][RID_W-1:0] src_id,
    output logic [CNT_W-1:0]                      ld_stall
);
    import stall_acct_pkg::*;

    logic [NSRC-1:0] hit;

    // Each source is checked on its own against the scoreboard (R3)
    for (genvar s = 0; s < NSRC; s++) begin : g_src
        assign hit[s] = src_vld[s] & active_mask[src_id[s]];
    end

    always_comb begin
        ld_stall = '0;
        for (int s = 0; s < NSRC; s++) begin
            if (hit[s]) ld_stall = ld_stall + CNT_W'(PEN);
        end
    end
endmodule

// File: rtl/load_scoreboard.sv
module load_scoreboard #(
    parameter int NREG = 16,
    localparam int RID_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid,
    input  logic             first,
    input  logic             ld_vld,
    input  logic [RID_W-1:0] ld_dst,
    output logic [NREG-1:0]  active_mask
);
    logic [NREG-1:0] pending_q;
    logic [NREG-1:0] pending_d;
    logic [NREG-1:0] dst_onehot;

    always_comb begin
        dst_onehot = '0;
        if (ld_vld) dst_onehot[ld_dst] = 1'b1;
        pending_d = (first ? '0 : pending_q) | dst_onehot;
    end

    // Collect, then publish one record later (R4)
    always_ff @(posedge clk) begin
        if (rst) begin
            pending_q   <= '0;
            active_mask <= '0;
        end else if (valid) begin
            pending_q   <= pending_d;
            active_mask <= pending_d;
        end
    end

    // R2
    idle_mask_chk: assert property (@(posedge clk) disable iff (rst)
        !valid |=> $stable(active_mask));
endmodule

// File: rtl/group_fsm.sv
module group_fsm #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid,
    input  logic             first,
    input  logic             last,
    input  logic [CNT_W-1:0] insn_total,
    output logic             charge_en,
    output logic [CNT_W-1:0] charge
);
    import stall_acct_pkg::*;

    grp_state_e       state, state_nxt;
    logic [CNT_W-1:0] held_q;
    logic [CNT_W-1:0] held_eff;

    always_comb begin
        state_nxt = state;
        unique case (state)
            S_SOLO:   if (valid && first && !last) state_nxt = S_PAIRED; // T_OPEN
            S_PAIRED: if (valid && last)           state_nxt = S_SOLO;   // T_CLOSE
            default:  state_nxt = S_SOLO;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_SOLO;
            held_q <= '0;
        end else begin
            state <= state_nxt;
            if (valid && !last) held_q <= insn_total;
        end
    end

    // Output process: the held maximum counts only inside an open group
    always_comb begin
        held_eff  = (state == S_PAIRED && !first) ? held_q : '0;
        charge    = (insn_total > held_eff) ? insn_total : held_eff;
        charge_en = valid && last;
    end
endmodule

// File: rtl/stall_accounter.sv
module stall_accounter #(
    parameter int NREG   = 16,
    parameter int CNT_W  = 32,
    parameter int BASE_W = 8,
    parameter int PEN    = 2,
    localparam int RID_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              iv_valid,
    input  logic              iv_first,
    input  logic              iv_last,
    input  logic [BASE_W-1:0] iv_base,
    input  logic              iv_src0_vld,
    input  logic [RID_W-1:0]  iv_src0,
    input  logic              iv_src1_vld,
    input  logic [RID_W-1:0]  iv_src1,
    input  logic              iv_ld_vld,
    input  logic [RID_W-1:0]  iv_ld_dst,
    input  logic              iv_br,
    input  logic              iv_br_taken,
    output logic [CNT_W-1:0]  tot_cycles,
    output logic [CNT_W-1:0]  ld_stall_cycles,
    output logic [CNT_W-1:0]  br_stall_cycles,
    output logic [CNT_W-1:0]  taken_cnt,
    output logic [CNT_W-1:0]  untaken_cnt
);
    import stall_acct_pkg::*;

    logic [NREG-1:0]            active_mask;
    logic [NSRC-1:0]            src_vld;
    logic [NSRC-1:0][RID_W-1:0] src_id;
    logic [CNT_W-1:0]           ld_stall;
    logic [CNT_W-1:0]           br_stall;
    logic [CNT_W-1:0]           insn_total;
    logic                       charge_en;
    logic [CNT_W-1:0]           charge;

    assign src_vld = {iv_src1_vld, iv_src0_vld};
    assign src_id  = {iv_src1, iv_src0};

    load_scoreboard #(.NREG(NREG)) u_sb (
        .clk(clk), .rst(rst), .valid(iv_valid), .first(iv_first),
        .ld_vld(iv_ld_vld), .ld_dst(iv_ld_dst), .active_mask(active_mask)
    );

    ld_hazard_probe #(.NREG(NREG), .CNT_W(CNT_W), .PEN(PEN)) u_probe (
        .active_mask(active_mask), .src_vld(src_vld), .src_id(src_id),
        .ld_stall(ld_stall)
    );

    assign br_stall   = (iv_br && iv_br_taken) ? CNT_W'(PEN) : '0;
    assign insn_total = CNT_W'(iv_base) + ld_stall + br_stall;

    group_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst(rst), .valid(iv_valid), .first(iv_first), .last(iv_last),
        .insn_total(insn_total), .charge_en(charge_en), .charge(charge)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tot_cycles      <= '0;
            ld_stall_cycles <= '0;
            br_stall_cycles <= '0;
            taken_cnt       <= '0;
            untaken_cnt     <= '0;
        end else if (iv_valid) begin
            if (charge_en) tot_cycles <= tot_cycles + charge;
            ld_stall_cycles <= ld_stall_cycles + ld_stall;
            br_stall_cycles <= br_stall_cycles + br_stall;
            if (iv_br && iv_br_taken)  taken_cnt   <= taken_cnt + CNT_W'(1);
            if (iv_br && !iv_br_taken) untaken_cnt <= untaken_cnt + CNT_W'(1);
        end
    end

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !iv_valid |=> ($stable(tot_cycles) && $stable(ld_stall_cycles)
                       && $stable(br_stall_cycles) && $stable(taken_cnt)));
    // R5
    taken_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (iv_valid && iv_br && iv_br_taken) |=> (taken_cnt == $past(taken_cnt) + CNT_W'(1)));
    // R5
    untaken_nostall_chk: assert property (@(posedge clk) disable iff (rst)
        (iv_valid && iv_br && !iv_br_taken) |=> $stable(br_stall_cycles));
    // R7
    defer_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (iv_valid && iv_first && !iv_last) |=> $stable(tot_cycles));
endmodule

// File: tb/test_stall_accounter.sv
module test_stall_accounter;
    localparam int CW = 12;
    localparam logic [CW-1:0] M = '1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic iv_valid = 0, iv_first = 0, iv_last = 0;
    logic [7:0] iv_base = 0;
    logic iv_src0_vld = 0, iv_src1_vld = 0, iv_ld_vld = 0, iv_br = 0, iv_br_taken = 0;
    logic [3:0] iv_src0 = 0, iv_src1 = 0, iv_ld_dst = 0;
    logic [CW-1:0] tot_cycles, ld_stall_cycles, br_stall_cycles, taken_cnt, untaken_cnt;

    int checks = 0;
    int failures = 0;
    logic [CW-1:0] t0, l0, b0, k0, u0;

    always #5 clk = ~clk;

    stall_accounter #(.NREG(16), .CNT_W(CW), .BASE_W(8), .PEN(2)) i_stall_accounter (
        .clk(clk), .rst(rst), .iv_valid(iv_valid), .iv_first(iv_first), .iv_last(iv_last),
        .iv_base(iv_base), .iv_src0_vld(iv_src0_vld), .iv_src0(iv_src0),
        .iv_src1_vld(iv_src1_vld), .iv_src1(iv_src1), .iv_ld_vld(iv_ld_vld),
        .iv_ld_dst(iv_ld_dst), .iv_br(iv_br), .iv_br_taken(iv_br_taken),
        .tot_cycles(tot_cycles), .ld_stall_cycles(ld_stall_cycles),
        .br_stall_cycles(br_stall_cycles), .taken_cnt(taken_cnt), .untaken_cnt(untaken_cnt)
    );

    task automatic chk(input string req, input logic [CW-1:0] got, input logic [CW-1:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic snap();
        t0 = tot_cycles; l0 = ld_stall_cycles; b0 = br_stall_cycles;
        k0 = taken_cnt; u0 = untaken_cnt;
    endtask

    // one record: f/l flags, base, s0v,s0, s1v,s1, ldv,ld, br,taken
    task automatic issue(input logic f, input logic l, input logic [7:0] base,
                         input logic s0v, input logic [3:0] s0,
                         input logic s1v, input logic [3:0] s1,
                         input logic ldv, input logic [3:0] ld,
                         input logic br, input logic tk);
        @(negedge clk);
        iv_valid = 1; iv_first = f; iv_last = l; iv_base = base;
        iv_src0_vld = s0v; iv_src0 = s0; iv_src1_vld = s1v; iv_src1 = s1;
        iv_ld_vld = ldv; iv_ld_dst = ld; iv_br = br; iv_br_taken = tk;
        @(negedge clk);
        iv_valid = 0;
    endtask

    task automatic single(input logic [7:0] base);
        issue(1, 1, base, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_reset();
        chk("R1 tot", tot_cycles, 0);
        chk("R1 ldst", ld_stall_cycles, 0);
        chk("R1 brst", br_stall_cycles, 0);
        chk("R1 taken", taken_cnt, 0);
        chk("R1 untaken", untaken_cnt, 0);
    endtask

    task automatic t_single();
        snap();
        single(3);
        chk("R6 single total", tot_cycles, t0 + 3);
    endtask

    task automatic t_load_use();
        single(1);  // start from a group with no loads
        snap();
        issue(1, 1, 1, 0, 0, 0, 0, 1, 5, 0, 0);
        issue(1, 1, 1, 1, 5, 0, 0, 0, 0, 0, 0);
        chk("R3 one source stall", ld_stall_cycles, l0 + 2);
        chk("R6 total with stall", tot_cycles, t0 + 1 + 3);
        snap();
        issue(1, 1, 1, 0, 0, 0, 0, 1, 15, 0, 0);
        issue(1, 1, 1, 1, 15, 1, 15, 0, 0, 0, 0);
        chk("R3 both sources", ld_stall_cycles, l0 + 4);
        snap();
        issue(1, 1, 1, 0, 0, 0, 0, 1, 0, 0, 0);
        issue(1, 1, 1, 0, 0, 1, 9, 0, 0, 0, 0);
        chk("R3 invalid source not charged", ld_stall_cycles, l0);
        chk("R3 invalid source total", tot_cycles, t0 + 2);
    endtask

    task automatic t_delay();
        issue(1, 1, 1, 0, 0, 0, 0, 1, 3, 0, 0);
        single(1);
        snap();
        issue(1, 1, 1, 1, 3, 0, 0, 0, 0, 0, 0);
        chk("R4 scoreboard cleared by next group", ld_stall_cycles, l0);
        // pair: first loads r7, second uses r7; next group uses r7 too
        snap();
        issue(1, 0, 1, 0, 0, 0, 0, 1, 7, 0, 0);
        issue(0, 1, 1, 1, 7, 0, 0, 0, 0, 0, 0);
        chk("R4 second member sees first load", ld_stall_cycles, l0 + 2);
        issue(1, 1, 1, 0, 0, 1, 7, 0, 0, 0, 0);
        chk("R4 next group sees pair load", ld_stall_cycles, l0 + 4);
    endtask

    task automatic t_branch();
        snap();
        issue(1, 1, 1, 0, 0, 0, 0, 0, 0, 1, 1);
        chk("R5 taken stall", br_stall_cycles, b0 + 2);
        chk("R5 taken count", taken_cnt, k0 + 1);
        chk("R5 taken total", tot_cycles, t0 + 3);
        issue(1, 1, 1, 0, 0, 0, 0, 0, 0, 1, 0);
        chk("R5 untaken no stall", br_stall_cycles, b0 + 2);
        chk("R5 untaken count", untaken_cnt, u0 + 1);
        issue(1, 1, 1, 0, 0, 0, 0, 0, 0, 0, 1);
        chk("R5 no branch taken", taken_cnt, k0 + 1);
        chk("R5 no branch untaken", untaken_cnt, u0 + 1);
    endtask

    task automatic t_pair();
        snap();
        issue(1, 0, 2, 0, 0, 0, 0, 0, 0, 1, 1);
        chk("R7 deferred total", tot_cycles, t0);
        chk("R9 stall added on first", br_stall_cycles, b0 + 2);
        issue(0, 1, 3, 0, 0, 0, 0, 0, 0, 0, 0);
        chk("R8 held max wins", tot_cycles, t0 + 4);
        snap();
        issue(1, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
        issue(0, 1, 5, 0, 0, 0, 0, 0, 0, 1, 1);
        chk("R8 closing member wins", tot_cycles, t0 + 7);
        chk("R9 stall added on last", br_stall_cycles, b0 + 2);
    endtask

    task automatic t_idle();
        snap();
        @(negedge clk);
        iv_first = 1; iv_last = 1; iv_base = 50; iv_br = 1; iv_br_taken = 1;
        iv_ld_vld = 1; iv_ld_dst = 4;
        @(negedge clk);
        @(negedge clk);
        chk("R2 idle tot", tot_cycles, t0);
        chk("R2 idle taken", taken_cnt, k0);
        issue(1, 1, 1, 1, 4, 0, 0, 0, 0, 0, 0);
        chk("R2 idle no load mark", ld_stall_cycles, l0);
    endtask

    task automatic t_wrap();
        snap();
        for (int i = 0; i < 17; i++) single(8'd255);
        chk("R10 wrap", tot_cycles, (t0 + 12'(17 * 255)) & M);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_single();
        t_load_use();
        t_delay();
        t_branch();
        t_pair();
        t_idle();
        t_wrap();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule